// File: doc/BRIEF.md
# Timestamped Sample Cluster Packer

This block stores a stream of 16-bit capture events in a compressed cluster format for a sample memory. Memory is organised as lines of 512 words (1024 bytes). A line holds 64 clusters of eight words each. Word 0 of a cluster is a timestamp, and words 1 to 7 carry up to seven events taken in consecutive sample periods. The timestamp counts accepted sample strobes since capture began. A decoder therefore rebuilds every sample: idle stretches between clusters repeat the last stored value over the timestamp jump.

A state machine sequences the capture through these states:
- **IDLE**: not capturing.
- **EMPTY**: capturing, no cluster opened yet.
- **FILL**: a cluster is open and has fewer than seven events.
- **SKIP**: the current cluster is complete, and samples equal to the last stored one are only counted.
- **FULL**: the memory is full and capture has ended.

The transitions are:
- **start**: any state to EMPTY.
- **stop**: EMPTY, FILL or SKIP to IDLE.
- **first**: EMPTY to FILL, on the first sample.
- **append**: FILL to FILL, or FILL to SKIP on the seventh event.
- **reopen**: SKIP to FILL, on a changed value or a forced gap.
- **overflow**: SKIP to FULL, when the next cluster would fall in the last line.

The block reports its write position and the position of a trigger in the same form: line number above bit 9, event index within the line in bits 8:0.

Top module: `cluster_packer`

## Requirements
- R1: After reset the block is in IDLE, with `capturing`, `mem_full`, `wr_en` and `trig_seen` at 0 and `wr_pos` at 0.
- R2: Memory layout:
  - Cluster number k (counted from 0 since start) occupies word addresses 8k to 8k+7.
  - The address bits above bit 9 hold the line number k/64, and bits 8:3 hold k mod 64.
  - Slot 0 holds the timestamp, and slots 1 to 7 hold events in arrival order.
- R3: The timestamp of an accepted sample is the number of samples accepted before it since start, modulo 65536. A cluster's timestamp word equals the timestamp of its first event, and its later events have timestamps +1 to +6.
- R4: While the open cluster holds fewer than seven events, every accepted sample is stored as its next event, even when it equals the previous one.
- R5: Once a cluster holds seven events, an accepted sample equal to the last stored event is not written. A differing sample opens the next cluster, with that sample as its first event.
- R6: In SKIP, an accepted sample opens a new cluster even when it is unchanged, if its timestamp minus the current cluster's timestamp (modulo 65536) is at least MAX_GAP.
- R7: `wr_pos` is {line, cluster*7 + events stored in that cluster}, which points just past the last stored event. After a line's last cluster fills, the index reads 448.
- R8: Capture ends on memory full:
  - When a new cluster would land in line LINES-1, capture stops and `mem_full` rises.
  - `wr_pos` then reads (LINES-1)<<9.
  - The sample that caused this is not stored, and nothing more is written until start.
- R9: Samples and triggers outside capture are ignored.
  - `cap_stop` ends capture, and a sample in the same cycle is dropped.
  - An event write still owed from the last opening is completed.
  - `wr_pos` holds.
- R10: The first `trig_in` that comes with an accepted sample (but not one that causes overflow) sets `trig_seen`. It latches into `trig_pos` the position of that sample's event, or `wr_pos` when the sample is not stored. Later triggers are ignored until start.
- R11: Write timing, with sample strobes at least two clocks apart:
  - A timestamp word appears on the write port in the cycle after its sample's strobe.
  - The first event of that cluster appears one cycle later.
  - An appended event appears in the cycle after its strobe.
- R12: `cap_start` restarts capture: the timestamp returns to 0, `wr_pos` to 0, and `mem_full` and `trig_seen` are cleared. `cap_start` has priority over `cap_stop` and samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_start | input | 1 | Begin a new capture |
| cap_stop | input | 1 | End the capture |
| smp_vld | input | 1 | Sample period strobe |
| smp_data | input | WORD_W | Event value for this period |
| trig_in | input | 1 | Trigger flag for this sample |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | log2(LINES)+9 | Memory word address |
| wr_data | output | WORD_W | Memory word (timestamp or event) |
| capturing | output | 1 | Capture in progress |
| mem_full | output | 1 | Capture ended on full memory |
| wr_pos | output | log2(LINES)+9 | Position just past last stored event |
| trig_seen | output | 1 | Trigger position latched |
| trig_pos | output | log2(LINES)+9 | Latched trigger position |

## Verification
A stream whose value changes every period shows that clusters are packed back to back, with timestamps stepping by seven, and that writes follow the right timing. A constant stream shows three things: a cluster fills even with repeated values, values are then skipped, and a forced cluster appears after MAX_GAP periods. A single change after a long constant run separates compression from storage. A shortened memory filled by a changing stream exercises the line crossing, the 448 index and overflow. Stop inside a cluster, triggers on stored and skipped samples, and a restart cover the remaining control paths.

// File: rtl/clpk_pkg.sv
package clpk_pkg;
    localparam int EV_PER_CL   = 7;
    localparam int CL_PER_LINE = 64;
    localparam int CL_W        = 6;
    localparam int SLOT_W      = 3;
    localparam int EVT_W       = 9;
    localparam int EV_PER_LINE = EV_PER_CL * CL_PER_LINE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMPTY,
        ST_FILL,
        ST_SKIP,
        ST_FULL
    } pk_state_e;
endpackage

// File: rtl/cp_tstamp.sv
module cp_tstamp #(
    parameter int W       = 16,
    parameter int MAX_GAP = 32768
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         mark,
    output logic [W-1:0] ts_now,
    output logic         gap_hit
);
    logic [W-1:0] base_q;
    logic [W-1:0] gap;
    logic [31:0]  gap32;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_now <= '0;
            base_q <= '0;
        end else if (clr) begin
            ts_now <= '0;
            base_q <= '0;
        end else begin
            if (adv)  ts_now <= ts_now + W'(1);
            if (mark) base_q <= ts_now;
        end
    end

    always_comb begin
        gap     = ts_now - base_q;
        gap32   = 32'(gap);
        gap_hit = gap32 >= 32'(MAX_GAP);
    end
endmodule

// File: rtl/cp_locator.sv
module cp_locator #(
    parameter int LINES = 32768
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        fresh,
    input  logic                        do_open,
    input  logic                        do_app,
    input  logic                        do_full,
    output logic [2:0]                  evt_n,
    output logic [$clog2(LINES)+8:0]    cur_pos,
    output logic [$clog2(LINES)+8:0]    open_pos,
    output logic [$clog2(LINES)+5:0]    open_cl,
    output logic [$clog2(LINES)+8:0]    app_addr,
    output logic                        hits_last
);
    import clpk_pkg::*;
    localparam int LINE_W = $clog2(LINES);

    logic [LINE_W-1:0] line_q, nx_line;
    logic [CL_W-1:0]   cl_q, nx_cl;
    logic [SLOT_W-1:0] n_q;
    logic [EVT_W-1:0]  evt_f, open_evt;

    always_comb begin
        nx_line   = fresh ? '0 : ((&cl_q) ? line_q + LINE_W'(1) : line_q);
        nx_cl     = fresh ? '0 : cl_q + CL_W'(1);
        hits_last = !fresh && (&cl_q) && (line_q == LINE_W'(LINES - 2));
        evt_f     = ({cl_q, 3'b000} - {3'b000, cl_q}) + {6'b0, n_q};
        open_evt  = {nx_cl, 3'b000} - {3'b000, nx_cl};
        cur_pos   = {line_q, evt_f};
        open_pos  = {nx_line, open_evt};
        open_cl   = {nx_line, nx_cl};
        app_addr  = {line_q, cl_q, n_q + SLOT_W'(1)};
        evt_n     = n_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            cl_q   <= '0;
            n_q    <= '0;
        end else if (clr) begin
            line_q <= '0;
            cl_q   <= '0;
            n_q    <= '0;
        end else if (do_full) begin
            line_q <= LINE_W'(LINES - 1);
            cl_q   <= '0;
            n_q    <= '0;
        end else if (do_open) begin
            line_q <= nx_line;
            cl_q   <= nx_cl;
            n_q    <= SLOT_W'(1);
        end else if (do_app) begin
            n_q    <= n_q + SLOT_W'(1);
        end
    end

    assert_evt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_pos[EVT_W-1:0] <= EVT_W'(EV_PER_LINE));
    assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_app |-> n_q < SLOT_W'(EV_PER_CL));
endmodule

// File: rtl/cp_wport.sv
module cp_wport #(
    parameter int AW = 24,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic [AW-1:0] a_addr,
    input  logic [WW-1:0] a_data,
    input  logic          hold,
    input  logic [AW-1:0] b_addr,
    input  logic [WW-1:0] b_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [WW-1:0] wr_data
);
    logic          pend_q;
    logic [AW-1:0] pa_q;
    logic [WW-1:0] pd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            pend_q  <= 1'b0;
            pa_q    <= '0;
            pd_q    <= '0;
        end else if (wr_a) begin
            wr_en   <= 1'b1;
            wr_addr <= a_addr;
            wr_data <= a_data;
            pend_q  <= hold;
            pa_q    <= b_addr;
            pd_q    <= b_data;
        end else if (pend_q) begin
            wr_en   <= 1'b1;
            wr_addr <= pa_q;
            wr_data <= pd_q;
            pend_q  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
        end
    end

    assert_port_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |-> !pend_q);
endmodule

// File: rtl/cluster_packer.sv
module cluster_packer #(
    parameter int WORD_W  = 16,
    parameter int LINES   = 32768,
    parameter int MAX_GAP = 32768
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_start,
    input  logic                     cap_stop,
    input  logic                     smp_vld,
    input  logic [WORD_W-1:0]        smp_data,
    input  logic                     trig_in,
    output logic                     wr_en,
    output logic [$clog2(LINES)+8:0] wr_addr,
    output logic [WORD_W-1:0]        wr_data,
    output logic                     capturing,
    output logic                     mem_full,
    output logic [$clog2(LINES)+8:0] wr_pos,
    output logic                     trig_seen,
    output logic [$clog2(LINES)+8:0] trig_pos
);
    import clpk_pkg::*;
    localparam int AW = $clog2(LINES) + 9;

    pk_state_e         state_q, state_d;
    logic              live, acc, changed, fresh;
    logic              do_open, do_app, do_full;
    logic [2:0]        evt_n;
    logic [AW-1:0]     open_pos, app_addr;
    logic [AW-4:0]     open_cl;
    logic              hits_last, gap_hit;
    logic [WORD_W-1:0] ts_now, last_q;

    assign live      = (state_q == ST_EMPTY) || (state_q == ST_FILL) || (state_q == ST_SKIP);
    assign acc       = live && smp_vld && !cap_start && !cap_stop;
    assign changed   = smp_data != last_q;
    assign fresh     = (state_q == ST_EMPTY);
    assign capturing = live;
    assign mem_full  = (state_q == ST_FULL);

    always_comb begin
        state_d = state_q;
        do_open = 1'b0;
        do_app  = 1'b0;
        do_full = 1'b0;
        if (cap_start) begin
            state_d = ST_EMPTY;
        end else if (cap_stop && live) begin
            state_d = ST_IDLE;
        end else if (acc) begin
            unique case (state_q)
                ST_EMPTY: begin
                    do_open = 1'b1;
                    state_d = ST_FILL;
                end
                ST_FILL: begin
                    do_app = 1'b1;
                    if (evt_n == 3'd6) state_d = ST_SKIP;
                end
                ST_SKIP: begin
                    if (changed || gap_hit) begin
                        if (hits_last) begin
                            do_full = 1'b1;
                            state_d = ST_FULL;
                        end else begin
                            do_open = 1'b1;
                            state_d = ST_FILL;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_seen <= 1'b0;
            trig_pos  <= '0;
            last_q    <= '0;
        end else begin
            if (cap_start) begin
                trig_seen <= 1'b0;
                trig_pos  <= '0;
            end else if (acc && trig_in && !trig_seen && !do_full) begin
                trig_seen <= 1'b1;
                trig_pos  <= do_open ? open_pos : wr_pos;
            end
            if (do_open || do_app) last_q <= smp_data;
        end
    end

    cp_tstamp #(.W(WORD_W), .MAX_GAP(MAX_GAP)) u_ts (
        .clk(clk), .rst_n(rst_n), .clr(cap_start), .adv(acc), .mark(do_open),
        .ts_now(ts_now), .gap_hit(gap_hit)
    );

    cp_locator #(.LINES(LINES)) u_loc (
        .clk(clk), .rst_n(rst_n), .clr(cap_start), .fresh(fresh),
        .do_open(do_open), .do_app(do_app), .do_full(do_full),
        .evt_n(evt_n), .cur_pos(wr_pos), .open_pos(open_pos), .open_cl(open_cl),
        .app_addr(app_addr), .hits_last(hits_last)
    );

    cp_wport #(.AW(AW), .WW(WORD_W)) u_wp (
        .clk(clk), .rst_n(rst_n), .wr_a(do_open || do_app),
        .a_addr(do_open ? {open_cl, 3'b000} : app_addr),
        .a_data(do_open ? ts_now : smp_data),
        .hold(do_open), .b_addr({open_cl, 3'b001}), .b_data(smp_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assert_ts_then_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:0] == 3'd0) |=> (wr_en && wr_addr == AW'($past(wr_addr) + 1'b1)));
    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full && !cap_start) |=> (mem_full && !capturing));
    assert_no_last_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[AW-1:9] != (AW-9)'(LINES - 1)));
    assert_trig_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_seen && !cap_start) |=> (trig_seen && $stable(trig_pos)));
    assert_strobe_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld);
endmodule

// File: tb/cluster_packer_tb.sv
module cluster_packer_tb;
    localparam int LINES = 4;
    localparam int MAXG  = 300;
    localparam int AW    = $clog2(LINES) + 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_start = 1'b0, cap_stop = 1'b0, smp_vld = 1'b0, trig_in = 1'b0;
    logic [15:0] smp_data = '0;
    logic wr_en, capturing, mem_full, trig_seen;
    logic [AW-1:0] wr_addr, wr_pos, trig_pos;
    logic [15:0] wr_data;

    always #2 clk = ~clk;

    cluster_packer #(.WORD_W(16), .LINES(LINES), .MAX_GAP(MAXG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_stop(cap_stop),
        .smp_vld(smp_vld), .smp_data(smp_data), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .capturing(capturing), .mem_full(mem_full), .wr_pos(wr_pos),
        .trig_seen(trig_seen), .trig_pos(trig_pos)
    );

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";
    bit armed = 0, done = 0;

    // reference model state
    int m_ts, m_base, m_cn, m_inc, m_last, m_tpos, m_paddr, m_pdata;
    bit m_cap, m_full, m_hit, m_pend;
    bit e_wr;
    int e_addr, e_data;

    function automatic int cur_pos();
        if (m_full) return (LINES - 1) << 9;
        if (m_cn < 0) return 0;
        return ((m_cn / 64) << 9) | ((m_cn % 64) * 7 + m_inc);
    endfunction

    task automatic chk(input string req, input string nm, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h exp %0h (t=%0t)", req, nm, got, exp, $time);
        end
    endtask

    task automatic model_step();
        int tnow, evpos;
        bit fnow;
        e_wr = 0;
        if (!rst_n) begin
            m_ts = 0; m_base = 0; m_cn = -1; m_inc = 0; m_last = 0; m_tpos = 0;
            m_cap = 0; m_full = 0; m_hit = 0; m_pend = 0;
            return;
        end
        if (m_pend) begin
            e_wr = 1; e_addr = m_paddr; e_data = m_pdata; m_pend = 0;
        end
        if (cap_start) begin
            m_cap = 1; m_full = 0; m_ts = 0; m_base = 0; m_cn = -1; m_inc = 0;
            m_hit = 0; m_tpos = 0;
        end else if (cap_stop) begin
            m_cap = 0;
        end else if (smp_vld && m_cap) begin
            tnow = m_ts;
            m_ts = (m_ts + 1) % 65536;
            fnow = 0;
            evpos = cur_pos();
            if (m_cn < 0 || (m_inc >= 7 && (int'(smp_data) != m_last ||
                             ((tnow - m_base + 65536) % 65536) >= MAXG))) begin
                if (m_cn >= 0 && (m_cn + 1) / 64 == LINES - 1) begin
                    m_full = 1; m_cap = 0; fnow = 1;
                end else begin
                    m_cn = m_cn + 1; m_inc = 1; m_base = tnow;
                    e_wr = 1; e_addr = m_cn * 8; e_data = tnow;
                    m_pend = 1; m_paddr = m_cn * 8 + 1; m_pdata = int'(smp_data);
                    m_last = int'(smp_data);
                    evpos = ((m_cn / 64) << 9) | ((m_cn % 64) * 7);
                end
            end else if (m_inc < 7) begin
                m_inc++;
                e_wr = 1; e_addr = m_cn * 8 + m_inc; e_data = int'(smp_data);
                m_last = int'(smp_data);
            end
            if (trig_in && !m_hit && !fnow) begin
                m_hit = 1; m_tpos = evpos;
            end
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            if (armed) begin
                chk(cur_req, "wr_en (R11)", int'(wr_en), int'(e_wr));
                if (e_wr && wr_en) begin
                    chk(cur_req, "wr_addr (R2)", int'(wr_addr), e_addr);
                    chk(cur_req, "wr_data (R3)", int'(wr_data), e_data);
                end
                chk(cur_req, "capturing", int'(capturing), int'(m_cap));
                chk(cur_req, "mem_full (R8)", int'(mem_full), int'(m_full));
                chk(cur_req, "wr_pos (R7)", int'(wr_pos), cur_pos());
                chk(cur_req, "trig_seen (R10)", int'(trig_seen), int'(m_hit));
                chk(cur_req, "trig_pos (R10)", int'(trig_pos), m_tpos);
            end
            model_step();
            armed = 1;
            if (cyc > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog: got timeout exp completion");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic smp(input int d, input bit t);
        smp_vld = 1; smp_data = 16'(d); trig_in = t; tick();
        smp_vld = 0; trig_in = 0; tick();
    endtask

    task automatic pulse_start();
        cap_start = 1; tick(); cap_start = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        cur_req = "R1";
        repeat (3) tick();
        chk("R1", "idle pos", int'(wr_pos), 0);
        cur_req = "R9";
        smp(16'h1234, 1);
        chk("R9", "idle trig", int'(trig_seen), 0);
        cur_req = "R4";
        pulse_start();
        for (int i = 0; i < 20; i++) smp(i * 3 + 1, 0);
        chk("R7", "pos after 20", int'(wr_pos), 20);
        cur_req = "R5";
        pulse_start();
        for (int i = 0; i < 14; i++) smp(16'hAAAA, 0);
        chk("R5", "pos after skip", int'(wr_pos), 7);
        smp(16'h5555, 0);
        chk("R5", "pos new cluster", int'(wr_pos), 8);
        cur_req = "R10";
        for (int i = 0; i < 8; i++) smp(16'h5555, 0);
        smp(16'h5555, 1);
        chk("R10", "trig on skipped", int'(trig_pos), 14);
        smp(16'h7777, 1);
        chk("R10", "second trig ignored", int'(trig_pos), 14);
        cur_req = "R6";
        for (int i = 0; i < 700; i++) smp(16'h7777, 0);
        cur_req = "R9";
        pulse_start();
        smp(1, 0); smp(2, 0); smp(3, 0);
        cap_stop = 1; smp_vld = 1; smp_data = 16'h9; tick();
        cap_stop = 0; smp_vld = 0; tick();
        smp(4, 1); smp(5, 0);
        chk("R9", "pos after stop", int'(wr_pos), 3);
        cur_req = "R8";
        pulse_start();
        for (int i = 0; i < 1400; i++) smp(i, (i == 500) ? 1'b1 : 1'b0);
        chk("R8", "full flag", int'(mem_full), 1);
        chk("R8", "full pos", int'(wr_pos), (LINES - 1) << 9);
        chk("R10", "trig in line 1", int'(trig_pos), (1 << 9) | (500 - 448));
        cur_req = "R12";
        pulse_start();
        chk("R12", "restart pos", int'(wr_pos), 0);
        chk("R12", "restart trig", int'(trig_seen), 0);
        smp(16'hBEEF, 0); smp(16'hBEEF, 0);
        repeat (4) tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule